// File: doc/BRIEF.md
# Scan Segment Select Cell

This block is a one-bit control cell inside a test data register. It decides whether an excludable scan segment that follows it is part of the active chain. The cell has a capture/shift stage and an update stage. The update stage holds the select value. The select only acts when the segment's power domain reports that it is ready to scan. While the segment is not inserted, a path multiplexer routes scan data around it, and the segment's Capture, Shift and Update enables are held inactive.

A tester reads the domain's readiness by capturing this cell. In the capture state the cell loads the ready-to-scan input. A second build option makes the same cell act as a domain control bit. Its update stage then also drives a power-enable request toward an external power controller. The TAP reset always returns the cell to the deselected state. A clamp-hold reset does the same when that option is built in. The segment's contents and the power controller are outside the block.

Top module: `seg_select_cell`

## Requirements
- R1: While `trst_n` is low, `sel_q`, `so`, `insert`, `not_ready`, `pwr_req` and the three gated enables are all 0. The reset acts asynchronously, at any time.
- R2: On a rising TCK edge with `shift_en`=1 and `cap_en`=0, `so` takes the value of `si`. With neither enable high, `so` holds its value.
- R3: On a rising TCK edge with `cap_en`=1, `so` takes the value of `seg_ready`. Capture wins over shift when both are high.
- R4: `sel_q` loads the current `so` value only on a rising edge with `upd_en`=1. Shifting or capturing never changes `sel_q`.
- R5: `insert` equals `sel_q` AND the value of `seg_ready` sampled at the latest rising edge. `chain_out` equals `seg_so` when `insert` is 1, and equals `so` otherwise.
- R6: `seg_cap`, `seg_shift` and `seg_upd` equal `cap_en`, `shift_en` and `upd_en` ANDed with `insert`. All three are 0 whenever the segment is bypassed.
- R7: If `seg_ready` is 0 at a rising edge, `insert` is 0 from that edge on, even though `sel_q` is 1.
- R8: `not_ready` is 1 exactly when `sel_q` is 1 and the sampled ready value is 0.
- R9: With the clamp-hold option built in (`CH_RST_OPT`=1, the default), a rising edge with `ch_rst`=1 clears `sel_q`. This takes priority over `upd_en`.
- R10: With the domain-control option built in (`PWR_CTRL_EN`=1, the default), `pwr_req` equals `sel_q`. Without the option it is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising-edge active |
| trst_n | input | 1 | TAP reset, active low, asynchronous assert |
| ch_rst | input | 1 | Clamp-hold reset request, synchronous |
| si | input | 1 | Scan data from the previous bit |
| cap_en | input | 1 | Local capture enable |
| shift_en | input | 1 | Local shift enable |
| upd_en | input | 1 | Local update enable |
| seg_ready | input | 1 | Ready-to-scan status from the segment's domain |
| seg_so | input | 1 | Scan output of the segment's last bit |
| so | output | 1 | Cell scan output, which also feeds the segment's scan input |
| sel_q | output | 1 | Updated select value |
| insert | output | 1 | Path multiplexer control, 1 means the segment is inserted |
| chain_out | output | 1 | Output of the path multiplexer toward the next bit |
| seg_cap | output | 1 | Gated capture enable for the segment |
| seg_shift | output | 1 | Gated shift enable for the segment |
| seg_upd | output | 1 | Gated update enable for the segment |
| not_ready | output | 1 | Selected but not ready, for diagnostics |
| pwr_req | output | 1 | Power-enable request for the domain |

## Verification
The select is written by shifting a 1 and then a 0 through the cell. Each value is applied with a separate update. This separates the shift stage from the update stage and shows that a new value in the shift flop does not change the select. The ready input is driven high, then dropped while the cell is selected, then raised again. This tells an inserted segment apart from a segment that is selected but not powered, on `chain_out`, the gated enables and the `not_ready` flag. Capture is run with ready at both levels, and once together with shift, so that a stale shift value cannot pass for the captured value. A clamp-hold reset and a TAP reset applied in the middle of the run confirm the return to the bypassed state.

// File: rtl/seg_sel_pkg.sv
package seg_sel_pkg;
  typedef struct packed {
    logic cap;
    logic shift;
    logic upd;
  } tdr_ctl_t;

  localparam tdr_ctl_t CTL_IDLE = '{cap: 1'b0, shift: 1'b0, upd: 1'b0};
endpackage

// File: rtl/ssc_tdr_bit.sv
module ssc_tdr_bit
  import seg_sel_pkg::*;
#(
  parameter bit CH_RST_OPT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ch_rst,
  input  logic     si,
  input  logic     cap_data,
  input  tdr_ctl_t ctl,
  output logic     so,
  output logic     upd_q
);
  logic sh_q, sh_d, up_d;
  logic ch_clr;
  logic ok_q;

  assign ch_clr = CH_RST_OPT && ch_rst;

  always_comb begin
    sh_d = sh_q;
    if (ctl.cap)        sh_d = cap_data;
    else if (ctl.shift) sh_d = si;
  end

  always_comb begin
    up_d = upd_q;
    if (ch_clr)       up_d = 1'b0;
    else if (ctl.upd) up_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 1'b0;
      upd_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      upd_q <= up_d;
      ok_q  <= 1'b1;
    end
  end

  assign so = sh_q;

  // R3: the capture result reflects the status sampled at that edge
  p_capture_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q && $past(ctl.cap) |-> so == $past(cap_data));
  // R4: select changes only after an update or a clamp-hold reset
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q && !$stable(upd_q) |-> $past(ctl.upd || ch_clr));
  // R2: a shift edge moves the scan input into the cell
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q && $past(ctl.shift && !ctl.cap) |-> so == $past(si));
endmodule

// File: rtl/ssc_gate.sv
module ssc_gate
  import seg_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel,
  input  logic     ready,
  input  tdr_ctl_t ctl_in,
  output logic     insert,
  output tdr_ctl_t ctl_out,
  output logic     mismatch
);
  logic rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= ready;
  end

  always_comb begin
    insert   = sel & rdy_q;
    mismatch = sel & ~rdy_q;
    ctl_out  = CTL_IDLE;
    if (insert) ctl_out = ctl_in;
  end

  // R6: a bypassed segment never sees an active enable
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !insert |-> ctl_out == CTL_IDLE);
  // R8: the diagnostic flag and insertion are exclusive
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mismatch && insert));
endmodule

// File: rtl/ssc_path_mux.sv
module ssc_path_mux #(
  parameter int W = 1
) (
  input  logic         insert,
  input  logic [W-1:0] bypass_d,
  input  logic [W-1:0] seg_d,
  output logic [W-1:0] out_d
);
  always_comb out_d = insert ? seg_d : bypass_d;
endmodule

// File: rtl/seg_select_cell.sv
module seg_select_cell
  import seg_sel_pkg::*;
#(
  parameter bit CH_RST_OPT  = 1'b1,
  parameter bit PWR_CTRL_EN = 1'b1
) (
  input  logic tck,
  input  logic trst_n,
  input  logic ch_rst,
  input  logic si,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic seg_ready,
  input  logic seg_so,
  output logic so,
  output logic sel_q,
  output logic insert,
  output logic chain_out,
  output logic seg_cap,
  output logic seg_shift,
  output logic seg_upd,
  output logic not_ready,
  output logic pwr_req
);
  tdr_ctl_t ctl, gctl;
  logic     ok_q;

  assign ctl = '{cap: cap_en, shift: shift_en, upd: upd_en};

  ssc_tdr_bit #(.CH_RST_OPT(CH_RST_OPT)) u_bit (
    .clk(tck), .rst_n(trst_n), .ch_rst(ch_rst), .si(si),
    .cap_data(seg_ready), .ctl(ctl), .so(so), .upd_q(sel_q)
  );

  ssc_gate u_gate (
    .clk(tck), .rst_n(trst_n), .sel(sel_q), .ready(seg_ready),
    .ctl_in(ctl), .insert(insert), .ctl_out(gctl), .mismatch(not_ready)
  );

  ssc_path_mux #(.W(1)) u_mux (
    .insert(insert), .bypass_d(so), .seg_d(seg_so), .out_d(chain_out)
  );

  assign seg_cap   = gctl.cap;
  assign seg_shift = gctl.shift;
  assign seg_upd   = gctl.upd;

  generate
    if (PWR_CTRL_EN) begin : g_pwr
      assign pwr_req = sel_q;
    end else begin : g_nopwr
      assign pwr_req = 1'b0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ok_q <= 1'b0;
    else         ok_q <= 1'b1;
  end

  // R7: a domain seen not ready at an edge forces the bypass path
  p_notready_bypass_r7: assert property (@(posedge tck) disable iff (!trst_n)
    ok_q && !$past(seg_ready) |-> chain_out == so);
  generate
    if (CH_RST_OPT) begin : g_chk
      // R9: clamp-hold reset leaves the cell deselected
      p_chrst_clear_r9: assert property (@(posedge tck) disable iff (!trst_n)
        ok_q && $past(ch_rst) |-> !sel_q && !insert);
    end
  endgenerate
endmodule

// File: tb/test_seg_select_cell.sv
module test_seg_select_cell;
  typedef struct {
    string req;
    logic  so, sel, ins, chain, gc, gs, gu, flag, pwr;
  } exp_t;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic ch_rst = 1'b0, si = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0;
  logic seg_ready = 1'b0, seg_so = 1'b0;
  logic so, sel_q, insert, chain_out, seg_cap, seg_shift, seg_upd, not_ready, pwr_req;

  int total = 0, bad = 0;
  int cycles = 0;
  exp_t q[$];
  logic m_sh = 1'b0, m_up = 1'b0, m_rdy = 1'b0;

  always #10 tck = ~tck;

  seg_select_cell i_seg_select_cell (
    .tck(tck), .trst_n(trst_n), .ch_rst(ch_rst), .si(si), .cap_en(cap_en),
    .shift_en(shift_en), .upd_en(upd_en), .seg_ready(seg_ready), .seg_so(seg_so),
    .so(so), .sel_q(sel_q), .insert(insert), .chain_out(chain_out),
    .seg_cap(seg_cap), .seg_shift(seg_shift), .seg_upd(seg_upd),
    .not_ready(not_ready), .pwr_req(pwr_req)
  );

  function automatic logic [8:0] pack_act();
    return {so, sel_q, insert, chain_out, seg_cap, seg_shift, seg_upd, not_ready, pwr_req};
  endfunction

  function automatic logic [8:0] pack_exp(exp_t e);
    return {e.so, e.sel, e.ins, e.chain, e.gc, e.gs, e.gu, e.flag, e.pwr};
  endfunction

  // driver: apply one cycle of stimulus and push what the edge must produce
  task automatic step(string req, logic i_si, logic c, logic s, logic u,
                      logic rdy, logic sso, logic ch);
    exp_t e;
    logic ins;
    @(negedge tck);
    si = i_si; cap_en = c; shift_en = s; upd_en = u;
    seg_ready = rdy; seg_so = sso; ch_rst = ch;
    if (ch)     m_up = 1'b0;
    else if (u) m_up = m_sh;
    if (c)      m_sh = rdy;
    else if (s) m_sh = i_si;
    m_rdy = rdy;
    ins = m_up & m_rdy;
    e.req = req; e.so = m_sh; e.sel = m_up; e.ins = ins;
    e.chain = ins ? sso : m_sh;
    e.gc = c & ins; e.gs = s & ins; e.gu = u & ins;
    e.flag = m_up & ~m_rdy; e.pwr = m_up;
    q.push_back(e);
  endtask

  // monitor: compare after each rising edge, away from the edge
  always @(posedge tck) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (pack_act() !== pack_exp(e)) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b (so,sel,ins,chain,gc,gs,gu,flag,pwr)",
                 e.req, pack_act(), pack_exp(e));
      end
    end
  end

  task automatic check_reset(string tag);
    total++;
    if (pack_act() !== 9'b0) begin
      bad++;
      $display("FAIL R1 %s: actual=%b expected=%b", tag, pack_act(), 9'b0);
    end
  endtask

  always @(posedge tck) begin
    cycles++;
    if (cycles > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    check_reset("initial");                 // R1
    trst_n = 1'b1;
    // R2: shift a 1 in with ready high; select unchanged
    step("R2", 1, 0, 1, 0, 1, 0, 0);
    step("R2 hold", 0, 0, 0, 0, 1, 0, 0);
    // R4 R5 R10: update inserts the segment; chain_out follows seg_so
    step("R4", 0, 0, 0, 1, 1, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 0);
    step("R5 seg0", 0, 0, 0, 0, 1, 0, 0);
    // R6: gated enables pass while inserted; R4: shifting a 0 keeps select
    step("R6 shift", 0, 0, 1, 0, 1, 1, 0);
    step("R4 midshift", 0, 0, 1, 0, 1, 0, 0);
    step("R6 cap", 0, 1, 0, 0, 1, 1, 0);
    // R7 R8: ready drops -> bypass, flag, enables blocked
    step("R7", 0, 0, 1, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0);
    step("R6 blocked", 0, 0, 1, 1, 0, 1, 0);
    // R3: capture status with ready low then high, and capture over shift
    step("R3 low", 1, 1, 0, 0, 0, 0, 0);
    step("R3 high", 0, 1, 0, 0, 1, 0, 0);
    step("R3 prio", 0, 1, 1, 0, 0, 1, 0);
    step("R3 prio2", 0, 1, 1, 0, 1, 1, 0);
    // R4: update re-arms select with captured 1, then ready back
    step("R4 re", 0, 0, 0, 1, 1, 1, 0);
    step("R5 back", 0, 0, 0, 0, 1, 1, 0);
    // R9: clamp-hold reset wins over update
    step("R9", 1, 0, 1, 0, 1, 1, 0);
    step("R9 ch", 0, 0, 0, 1, 1, 1, 1);
    step("R9 after", 0, 0, 0, 0, 1, 1, 0);
    // R4: update writes 0 -> deselect
    step("R4 set", 1, 0, 0, 1, 1, 1, 0);
    step("R4 zero", 0, 0, 1, 0, 1, 0, 0);
    step("R4 clr", 0, 0, 0, 1, 1, 1, 0);
    step("R4 idle", 0, 0, 0, 0, 1, 1, 0);
    // select again, then TAP reset mid-run
    step("R2 one", 1, 0, 1, 0, 1, 1, 0);
    step("R10", 0, 0, 0, 1, 1, 1, 0);
    @(negedge tck);
    @(negedge tck);
    trst_n = 1'b0;
    #2;
    check_reset("async");                   // R1
    m_sh = 1'b0; m_up = 1'b0; m_rdy = 1'b0;
    @(negedge tck);
    check_reset("held");                    // R1
    trst_n = 1'b1;
    step("R1 after", 0, 0, 0, 0, 1, 1, 0);
    @(negedge tck);
    @(negedge tck);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule